// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address order for one memory burst. A start strobe captures a start column address, a burst length of 4 or 8 beats, and an ordering choice: wrap-around counting or XOR interleaving. The block then presents one column address per beat. Each beat carries a valid flag, and the final beat also raises a last flag. An advance input moves the burst on by one beat. The block changes only the three lowest column bits. Every column bit from bit 3 upward is passed through unchanged from the captured start address.

Control is a two-state machine. In `ST_IDLE` the outputs are idle, and the block waits for a start strobe. The transition named *launch* (`ST_IDLE` to `ST_BURST`, on `start`) captures the inputs and sets the beat index to 0. In `ST_BURST` the transition named *step* (`ST_BURST` to `ST_BURST`, on `advance` when the beat is not the final one) increments the beat index. The transition named *finish* (`ST_BURST` to `ST_IDLE`, on `advance` at the final beat) closes the burst. The address shown for beat i follows from the captured offset s (start bits 2:0), the index i, the length and the ordering.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. After that edge `beat_valid` and `beat_last` are 0, and both stay 0 until a start is accepted.
- R2: A `start` that is seen while idle is accepted. In the following cycle `beat_valid` is 1 and `col_out` is equal to the captured start column address (beat 0).
- R3: Length 4 (`len8`=0), sequential (`ilv`=0): low bits [1:0] of beat i are (s[1:0]+i) mod 4. For example, s=1 gives 1,2,3,0.
- R4: Length 4, interleaved (`ilv`=1): low bits [1:0] of beat i are s[1:0] XOR i. For example, s=1 gives 1,0,3,2 and s=3 gives 3,2,1,0.
- R5: Length 8 (`len8`=1), sequential: bits [1:0] are (s[1:0]+i) mod 4. Bit 2 is s[2] for beats 0 to 3 and the inverse of s[2] for beats 4 to 7. For example, s=5 gives 5,6,7,4,1,2,3,0.
- R6: Length 8, interleaved: bits [2:0] of beat i are s XOR i. For example, s=5 gives 5,4,7,6,1,0,3,2.
- R7: Column bits from bit 3 upward are equal to the captured start bits on every beat of the burst.
- R8: `beat_last` is 1 only on beat 3 (length 4) or beat 7 (length 8). If `advance` is high on that beat, `beat_valid` is 0 in the next cycle.
- R9: A `start` seen during a burst has no effect. The burst carries on with its own addresses, length and ordering.
- R10: While `advance` is low during a burst, `col_out`, `beat_valid` and `beat_last` hold their values.
- R11: At length 4, bit 2 of every beat is equal to s[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only while idle |
| start_col | input | COL_W | Start column address |
| len8 | input | 1 | Burst length: 1 = 8 beats, 0 = 4 beats |
| ilv | input | 1 | Ordering: 1 = interleaved, 0 = sequential |
| advance | input | 1 | Consume the current beat and step to the next one |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | Current beat is valid |
| beat_last | output | 1 | Current beat is the final beat of the burst |

## Verification
The bench builds the block with `COL_W` = 12. This gives nine pass-through bits, which can carry distinctive patterns, so any disturbance of the upper bits during a burst shows up in the comparison. The low-bit offsets are swept over all eight values, at both lengths and in both orderings. Bursts are run with continuous advance and with gapped advance. A conflicting start strobe is injected in the middle of a burst, so that the hold and ignore behaviour is exercised alongside the address order.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int OFS_W = 3;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_t;
endpackage

// File: rtl/bcs_beat_fsm.sv
module bcs_beat_fsm
    import bcs_pkg::*;
#(
    parameter int BEAT_W = OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              advance,
    input  logic              len8_q,
    output logic              load,
    output logic              valid,
    output logic              last,
    output logic [BEAT_W-1:0] beat
);
    localparam logic [BEAT_W-1:0] END4 = BEAT_W'(3);
    localparam logic [BEAT_W-1:0] END8 = BEAT_W'(7);

    seq_state_t state, nxt;
    logic       at_end;

    assign at_end = (beat == (len8_q ? END8 : END4));
    assign load   = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_BURST;                  // launch
            ST_BURST: if (advance && at_end) nxt = ST_IDLE;       // finish
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                                      beat <= '0;
        else if (load)                                beat <= '0;
        else if (state == ST_BURST && advance && !at_end) beat <= beat + 1'b1; // step
    end

    always_comb begin
        valid = (state == ST_BURST);
        last  = (state == ST_BURST) && at_end;
    end

    a_r8_last_only_when_valid: assert property (@(posedge clk) disable iff (rst)
        last |-> valid);
    a_r8_finish_drops_valid: assert property (@(posedge clk) disable iff (rst)
        (valid && last && advance) |=> !valid);
    a_r2_launch_beat_zero: assert property (@(posedge clk) disable iff (rst)
        (!valid && start) |=> (valid && beat == '0));
    a_r9_start_ignored_mid_burst: assert property (@(posedge clk) disable iff (rst)
        (valid && !advance) |=> (valid && $stable(beat)));
endmodule

// File: rtl/bcs_addr_map.sv
module bcs_addr_map
    import bcs_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  logic [OFS_W-1:0] beat,
    input  logic             len8,
    input  order_t           order,
    output logic [OFS_W-1:0] low
);
    logic [1:0] rot;
    logic [1:0] mix;
    logic       grp;

    always_comb begin
        rot = ofs[1:0] + beat[1:0];
        mix = ofs[1:0] ^ beat[1:0];
        grp = len8 ? (ofs[2] ^ beat[2]) : ofs[2];
        unique case (order)
            ORD_SEQ: low = {grp, rot};
            ORD_ILV: low = {grp, mix};
            default: low = ofs;
        endcase
    end

    always_comb begin
        if (beat == '0) a_r2_beat0_is_start: assert (low == ofs);
        if (!len8)      a_r11_bl4_keeps_a2: assert (low[2] == ofs[2]);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             len8,
    input  logic             ilv,
    input  logic             advance,
    output logic [COL_W-1:0] col_out,
    output logic             beat_valid,
    output logic             beat_last
);
    localparam int UP_W = COL_W - OFS_W;

    logic [COL_W-1:0] col_q;
    logic             len8_q;
    order_t           order_q;
    logic             load;
    logic [OFS_W-1:0] beat;
    logic [OFS_W-1:0] low;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q   <= '0;
            len8_q  <= 1'b0;
            order_q <= ORD_SEQ;
        end else if (load) begin
            col_q   <= start_col;
            len8_q  <= len8;
            order_q <= ilv ? ORD_ILV : ORD_SEQ;
        end
    end

    bcs_beat_fsm #(.BEAT_W(OFS_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .advance (advance),
        .len8_q  (len8_q),
        .load    (load),
        .valid   (beat_valid),
        .last    (beat_last),
        .beat    (beat)
    );

    bcs_addr_map u_map (
        .ofs   (col_q[OFS_W-1:0]),
        .beat  (beat),
        .len8  (len8_q),
        .order (order_q),
        .low   (low)
    );

    generate
        if (UP_W > 0) begin : g_upper
            assign col_out = {col_q[COL_W-1:OFS_W], low};
        end else begin : g_low_only
            assign col_out = low[COL_W-1:0];
        end
    endgenerate

    a_r7_upper_constant: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && $past(beat_valid)) |-> (col_out[COL_W-1:OFS_W] == $past(col_out[COL_W-1:OFS_W])));
    a_r10_hold_without_advance: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !advance) |=> (beat_valid && $stable(col_out) && $stable(beat_last)));
endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
    localparam int COL_W = 12;

    typedef struct {
        logic [COL_W-1:0] col;
        logic             last;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             len8 = 1'b0;
    logic             ilv = 1'b0;
    logic             advance = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             beat_valid;
    logic             beat_last;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) uut (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len8(len8), .ilv(ilv), .advance(advance),
        .col_out(col_out), .beat_valid(beat_valid), .beat_last(beat_last)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_low(input logic [2:0] s, input int i,
                                           input logic l8, input logic il);
        logic [1:0] lo;
        logic       g;
        if (il) begin
            lo = s[1:0] ^ 2'(i);
            g  = l8 ? (s[2] ^ ((i >= 4) ? 1'b1 : 1'b0)) : s[2];
        end else begin
            lo = 2'((int'(s[1:0]) + i) % 4);
            g  = (l8 && i >= 4) ? ~s[2] : s[2];
        end
        return {g, lo};
    endfunction

    // monitor: every beat consumed at the next edge is compared with the scoreboard
    always @(negedge clk) begin
        if (!rst && beat_valid && advance) begin
            if (sb.size() == 0) begin
                check("R8 extra beat", 32'(col_out), 32'hFFFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " col"}, 32'(col_out), 32'(e.col));
                check({e.tag, " last R8"}, 32'(beat_last), 32'(e.last));
            end
        end
    end

    task automatic run_burst(input logic [COL_W-1:0] sc, input logic l8, input logic il,
                             input bit gaps, input bit poke, input string tag);
        int n;
        int cyc;
        n = l8 ? 8 : 4;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.col  = {sc[COL_W-1:3], exp_low(sc[2:0], i, l8, il)};
            e.last = (i == n - 1);
            e.tag  = tag;
            sb.push_back(e);
        end
        start = 1'b1; start_col = sc; len8 = l8; ilv = il; advance = 1'b0;
        @(posedge clk); #1;
        start = 1'b0; start_col = ~sc; len8 = ~l8; ilv = ~il;
        check("R2 valid after start", 32'(beat_valid), 32'd1);
        check("R2 beat0 addr", 32'(col_out), 32'(sc));
        cyc = 0;
        while (sb.size() != 0) begin
            advance = gaps ? (cyc % 3 != 1) : 1'b1;
            start   = poke && (cyc == 2);   // R9: start during burst must be ignored
            @(posedge clk); #1;
            cyc++;
        end
        advance = 1'b0; start = 1'b0;
        check("R8 valid drops after last", 32'(beat_valid), 32'd0);
        check("R8 last low after burst", 32'(beat_last), 32'd0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", 32'(beat_valid), 32'd0);
        check("R1 reset last", 32'(beat_last), 32'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 idle valid", 32'(beat_valid), 32'd0);
        for (int s = 0; s < 8; s++) begin
            run_burst({9'h1A5 + 9'(s), 3'(s)}, 1'b0, 1'b0, s[0], 1'b0, "R3 bl4 seq R11 R7");
            run_burst({9'h0F0 ^ 9'(s), 3'(s)}, 1'b0, 1'b1, 1'b0, s[1], "R4 bl4 ilv R11 R7");
            run_burst({9'h155, 3'(s)}, 1'b1, 1'b0, s[0], 1'b0, "R5 bl8 seq R7");
            run_burst({9'h0AA, 3'(s)}, 1'b1, 1'b1, 1'b1, 1'b0, "R6 bl8 ilv R7");
        end
        run_burst(12'hE05, 1'b1, 1'b0, 1'b1, 1'b1, "R9 poke bl8 seq R10");
        run_burst(12'h7FB, 1'b1, 1'b1, 1'b0, 1'b1, "R9 poke bl8 ilv");
        check("R8 scoreboard drained", 32'(sb.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule